// File: doc/BRIEF.md
# Partitioned Distributed-Arithmetic FIR Filter

This block is a fixed-coefficient FIR filter that has no multipliers. The tap delay line is loaded with a whole sample at once. The block then walks through the bits of every tap, K bit positions per fast clock cycle. For each bit position, the taps are grouped into partitions of at most `PART` taps. Each partition has a small constant table. The table is indexed by the current bit of each tap in the group, and each entry holds the sum of the coefficients whose address bit is set. A balanced adder tree joins the table outputs. The K per-bit sums are weighted by their bit position, and the sum for the sign bit is subtracted. A barrel-shifted accumulator collects the result across the `DW/K` folding cycles.

Samples enter through a valid/ready stream. The filter takes one sample per folding period. In the final folding cycle it raises `in_ready` again, so a source that holds `in_valid` high gets a new sample in every `DW/K` cycles with no gap. A sample is taken only on a cycle where `in_valid` and `in_ready` are both high. A source that sees `in_ready` low must keep `in_valid` and `in_data` steady until the handshake happens. The output side has no back-pressure: `out_valid` is a one-cycle strobe and `out_data` holds its value until the next result. Input and output use signed Q1.11 format (12 bits, 11 fractional bits). Coefficients are signed Q0.16 (16 bits, 16 fractional bits) and are fixed when the design is elaborated. `K` must divide `DW`.

Top module: `dafir_fir`

## Requirements
- R1: Every result equals round(P / 2^16) saturated to [-2048, 2047], where P = Σ x[n-i]·c[i]. Here x[n-i] is the i-th most recent accepted integer sample (i = 0 is the newest) and c[i] is the integer coefficient of tap i.
- R2: While reset is held and after it is released, `in_ready` is 1 and `out_valid` is 0.
- R3: The result for a sample appears, with `out_valid` high for exactly one cycle, on the `FOLD` = DW/K-th rising edge after the edge that accepted the sample.
- R4: After a handshake `in_ready` stays low until the last folding cycle and is high in that cycle. A held `in_valid` is therefore accepted exactly every `FOLD` cycles, and nothing is taken while `in_ready` is low.
- R5: The tap delay line moves by one position only on a handshake edge.
- R6: A result above 2047 is output as 2047, and a result below -2048 is output as -2048.
- R7: Rounding is to nearest, and an exact half fraction rounds toward plus infinity (62.5 gives 63, -62.5 gives -62).
- R8: The bit at position DW-1 of each tap has weight -2^(DW-1), so a full-scale negative input (-2048) filters correctly.
- R9: When `NTAPS` is not a multiple of `PART`, the taps in the last, shorter partition still contribute their coefficients. The default is 10 taps in partitions of 4, 4 and 2.
- R10: The number of bits handled per cycle is the parameter `K`, with one table set per parallel bit. The folding period is DW/K cycles, which is 4 for the default K = 3.
- R11: For every bit position, the adder tree output equals the plain sum of all partition table outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, `FOLD` cycles per sample period |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Source has a sample on `in_data` |
| in_ready | output | 1 | Filter can take a sample this cycle |
| in_data | input | DW | Signed Q1.11 input sample |
| out_valid | output | 1 | One-cycle strobe: `out_data` has just been updated |
| out_data | output | DW | Signed Q1.11 filtered result |

## Verification
The assertions assume that reset is applied before the first handshake and that `DW` is a multiple of `K`. They also assume the source obeys the stream rule: once `in_valid` is raised, it and the data stay unchanged until `in_ready` is seen high. The stimulus raises `in_valid` on a falling edge and keeps the sample steady while `in_ready` is low. It drops the strobe only after the handshake edge, either leaving random idle gaps or moving straight to the next sample so that back-to-back acceptance is exercised. Samples come from a fixed-seed random stream plus directed impulses, steps and half-LSB rounding cases, all within the 12-bit signed range.

// File: rtl/dafir_pkg.sv
package dafir_pkg;
  // Default coefficient set: signed Q0.16, tap 0 in the low field.
  localparam int DEF_TAPS = 10;
  localparam int DEF_CW   = 16;
  localparam logic [DEF_TAPS*DEF_CW-1:0] DEF_COEFS = {
    16'hF448, 16'hF63C, 16'h1770, 16'h4E20, 16'h7D00,
    16'h7D00, 16'h4E20, 16'h1770, 16'hF63C, 16'hF448
  };

  // Number of partitions for a given tap count and partition size.
  function automatic int num_parts(input int taps, input int part);
    return (taps + part - 1) / part;
  endfunction
endpackage

// File: rtl/dafir_lut.sv
module dafir_lut #(
  parameter int CW    = 16,
  parameter int NTAPS = 10,
  parameter int PART  = 4,
  parameter int BASE  = 0,
  parameter int TW    = 19,
  parameter logic [NTAPS*CW-1:0] COEFS = '0
) (
  input  logic [PART-1:0]        addr,
  output logic signed [TW-1:0]   val
);
  localparam int DEPTH = 1 << PART;

  // Entry e holds the sum of the coefficients whose address bit is set.
  function automatic logic signed [TW-1:0] entry(input int e);
    int s;
    int idx;
    s = 0;
    for (int b = 0; b < PART; b++) begin
      idx = (BASE + b < NTAPS) ? BASE + b : 0;
      if (((e >> b) & 1) == 1 && (BASE + b < NTAPS))
        s += int'($signed(COEFS[idx*CW +: CW]));
    end
    return TW'(s);
  endfunction

  logic signed [TW-1:0] tbl [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    localparam logic signed [TW-1:0] EV = entry(e);
    assign tbl[e] = EV;
  end

  assign val = tbl[addr];
endmodule

// File: rtl/dafir_slice.sv
module dafir_slice #(
  parameter int CW    = 16,
  parameter int NTAPS = 10,
  parameter int PART  = 4,
  parameter int TW    = 19,
  parameter int SW    = 22,
  parameter logic [NTAPS*CW-1:0] COEFS = '0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NTAPS-1:0]       bits,
  output logic signed [SW-1:0]   total
);
  localparam int NPART = dafir_pkg::num_parts(NTAPS, PART);
  localparam int NP2   = 1 << $clog2(NPART);
  localparam int NODES = 2 * NP2 - 1;

  logic [NPART*PART-1:0] padded;
  logic signed [TW-1:0]  part_val [NPART];
  logic signed [SW-1:0]  node [NODES];

  assign padded = (NPART*PART)'(bits);

  // Leaves: one table per partition, zero for padding slots.
  for (genvar p = 0; p < NP2; p++) begin : g_leaf
    if (p < NPART) begin : g_tab
      dafir_lut #(
        .CW(CW), .NTAPS(NTAPS), .PART(PART), .BASE(p*PART), .TW(TW), .COEFS(COEFS)
      ) i_lut (
        .addr (padded[p*PART +: PART]),
        .val  (part_val[p])
      );
      assign node[NP2-1+p] = SW'(part_val[p]);
    end else begin : g_pad
      assign node[NP2-1+p] = '0;
    end
  end

  // Balanced tree in heap order: node n sums nodes 2n+1 and 2n+2.
  for (genvar n = 0; n < NP2 - 1; n++) begin : g_add
    assign node[n] = node[2*n+1] + node[2*n+2];
  end

  assign total = node[0];

  // Linear reference sum for the tree check.
  logic signed [SW-1:0] chain_sum;
  always_comb begin
    chain_sum = '0;
    for (int p = 0; p < NPART; p++) chain_sum = chain_sum + SW'(part_val[p]);
  end

  AST_TREE_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    total == chain_sum); // R11
endmodule

// File: rtl/dafir_ctrl.sv
module dafir_ctrl #(
  parameter int FOLD = 4,
  localparam int CNTW = (FOLD > 1) ? $clog2(FOLD) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  output logic            accept,
  output logic            busy,
  output logic            last,
  output logic [CNTW-1:0] cnt
);
  localparam logic [CNTW-1:0] CNT_END = CNTW'(FOLD - 1);

  assign last     = busy && (cnt == CNT_END);
  assign in_ready = !busy || last;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (last) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      cnt  <= cnt + 1'b1;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt <= CNT_END); // R10
  AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> cnt == '0); // R3
  AST_READY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && FOLD > 1) |=> !in_ready); // R4
endmodule

// File: rtl/dafir_fir.sv
module dafir_fir #(
  parameter int DW    = 12,
  parameter int CW    = 16,
  parameter int NTAPS = dafir_pkg::DEF_TAPS,
  parameter int PART  = 4,
  parameter int K     = 3,
  parameter logic [NTAPS*CW-1:0] COEFS = dafir_pkg::DEF_COEFS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [DW-1:0]        in_data,
  output logic                 out_valid,
  output logic [DW-1:0]        out_data
);
  localparam int FOLD  = DW / K;
  localparam int CNTW  = (FOLD > 1) ? $clog2(FOLD) : 1;
  localparam int NPART = dafir_pkg::num_parts(NTAPS, PART);
  localparam int TW    = CW + $clog2(PART) + 1;
  localparam int SW    = TW + $clog2(NPART) + 1;
  localparam int W     = DW + CW + $clog2(NTAPS) + 2;
  localparam logic signed [W-1:0] OMAX = (W'(1) <<< (DW-1)) - W'(1);
  localparam logic signed [W-1:0] OMIN = -OMAX - W'(1);
  localparam logic signed [W-1:0] HALF = W'(1) <<< (CW-1);

  logic            accept, busy, last;
  logic [CNTW-1:0] cnt;

  dafir_ctrl #(.FOLD(FOLD)) i_ctrl (
    .clk, .rst_n, .in_valid, .in_ready,
    .accept, .busy, .last, .cnt
  );

  // Tap delay line (tap 0 newest) and bit serialiser.
  logic [NTAPS*DW-1:0] tapline, sr, next_line;
  assign next_line = {tapline[(NTAPS-1)*DW-1:0], in_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tapline <= '0;
      sr      <= '0;
    end else if (accept) begin
      tapline <= next_line;
      sr      <= next_line;
    end else if (busy) begin
      for (int i = 0; i < NTAPS; i++) sr[i*DW +: DW] <= sr[i*DW +: DW] >> K;
    end
  end

  // One table set per parallel bit.
  logic [NTAPS-1:0]     slice_bits [K];
  logic signed [SW-1:0] slice_sum  [K];

  always_comb begin
    for (int j = 0; j < K; j++)
      for (int i = 0; i < NTAPS; i++) slice_bits[j][i] = sr[i*DW + j];
  end

  for (genvar j = 0; j < K; j++) begin : g_set
    dafir_slice #(
      .CW(CW), .NTAPS(NTAPS), .PART(PART), .TW(TW), .SW(SW), .COEFS(COEFS)
    ) i_slice (
      .clk, .rst_n,
      .bits  (slice_bits[j]),
      .total (slice_sum[j])
    );
  end

  // Weight the K partial sums; the top bit of the word counts negative.
  logic signed [W-1:0] comb_sum, contrib, full, rnd, term;
  always_comb begin
    comb_sum = '0;
    for (int j = 0; j < K; j++) begin
      term = W'(slice_sum[j]) <<< j;
      if (last && j == K - 1) comb_sum = comb_sum - term;
      else                    comb_sum = comb_sum + term;
    end
  end

  assign contrib = comb_sum <<< (int'(cnt) * K);

  logic signed [W-1:0] acc;
  assign full = acc + contrib;
  assign rnd  = (full + HALF) >>> CW;

  logic [DW-1:0] sat_val;
  always_comb begin
    if (rnd > OMAX)      sat_val = OMAX[DW-1:0];
    else if (rnd < OMIN) sat_val = OMIN[DW-1:0];
    else                 sat_val = rnd[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= last;
      if (last) begin
        acc      <= '0;
        out_data <= sat_val;
      end else if (busy) begin
        acc      <= full;
      end
    end
  end

  AST_TAPS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(tapline)); // R5
  AST_OUT_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(last)); // R3
  AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(rnd > OMAX)) |-> out_data == OMAX[DW-1:0]); // R6
  AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(rnd < OMIN)) |-> out_data == OMIN[DW-1:0]); // R6
endmodule

// File: tb/test_dafir_fir.sv
module test_dafir_fir;
  localparam int NT   = 10;
  localparam int FOLD = 4;
  localparam int QM   = 511;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [11:0] in_data = '0;
  logic out_valid;
  logic [11:0] out_data;

  always #2.5 clk = ~clk;

  dafir_fir i_dafir_fir (
    .clk, .rst_n, .in_valid, .in_ready, .in_data, .out_valid, .out_data
  );

  int coef [NT] = '{-3000, -2500, 6000, 20000, 32000, 32000, 20000, 6000, -2500, -3000};
  int hist [NT];
  int nchk = 0, nfail = 0;
  int cyc = 0;
  int exp_val [QM+1];
  int exp_cyc [QM+1];
  string exp_tag [QM+1];
  int wr = 0, rd = 0;
  int prev_acc = 0;
  bit have_prev = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Bit-true direct-form model: round half up, then saturate.
  function automatic int model_out();
    longint p = 0;
    longint r;
    for (int i = 0; i < NT; i++) p += longint'(hist[i]) * longint'(coef[i]);
    r = (p + 64'sd32768) >>> 16;
    if (r > 2047) r = 2047;
    if (r < -2048) r = -2048;
    return int'(r);
  endfunction

  // Present one sample at a falling edge and hold it until the handshake.
  task automatic send(input int x, input bit burst, input string tag);
    bit rdy;
    in_valid = 1'b1;
    in_data  = 12'(x);
    forever begin
      rdy = in_ready;
      @(negedge clk);
      if (rdy) break;
    end
    in_valid = 1'b0;
    for (int i = NT - 1; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = x;
    exp_val[wr & QM] = model_out();
    exp_cyc[wr & QM] = cyc;
    exp_tag[wr & QM] = tag;
    wr++;
    // R4: a held strobe is taken once per folding period.
    if (burst && have_prev) chk(cyc - prev_acc == FOLD, "R4", cyc - prev_acc, FOLD);
    prev_acc = cyc;
    have_prev = 1'b1;
  endtask

  // Output monitor: value (R1, R11) and latency (R3, R10).
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (rd == wr) begin
        chk(1'b0, "R3", 1, 0);
      end else begin
        chk($signed(out_data) == exp_val[rd & QM], exp_tag[rd & QM],
            int'($signed(out_data)), exp_val[rd & QM]);
        chk(cyc - exp_cyc[rd & QM] == FOLD, "R10", cyc - exp_cyc[rd & QM], FOLD);
        rd++;
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    have_prev = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < NT; i++) hist[i] = 0;
    void'($urandom(32'd1299));
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R2", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R2", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R2", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R2", int'(out_valid), 0);

    // R9: positive impulse walks through every coefficient, incl. the short partition.
    send(2047, 1'b0, "R9");
    for (int i = 0; i < NT + 1; i++) send(0, 1'b1, "R9");
    // R8: full-scale negative impulse exercises the negative sign-bit weight.
    idle(2);
    send(-2048, 1'b0, "R8");
    for (int i = 0; i < NT + 1; i++) send(0, 1'b1, "R8");
    // R7: 128 * 32000 = 62.5 LSB -> 63; -128 * 32000 = -62.5 LSB -> -62.
    idle(1);
    send(128, 1'b0, "R7");
    for (int i = 0; i < NT; i++) send(0, 1'b1, "R7");
    send(-128, 1'b1, "R7");
    for (int i = 0; i < NT; i++) send(0, 1'b1, "R7");
    // R6: full-scale steps drive the DC gain of 1.6 into both rails.
    send(2047, 1'b1, "R6");
    for (int i = 0; i < NT + 3; i++) send(2047, 1'b1, "R6");
    for (int i = 0; i < NT + 4; i++) send(-2048, 1'b1, "R6");
    // R1, R5: random samples with random idle gaps between handshakes.
    for (int n = 0; n < 300; n++) begin
      int gap = int'($urandom_range(0, 3));
      if (gap > 0) idle(gap);
      send(int'($signed(12'($urandom))), gap == 0, "R1");
    end
    repeat (FOLD + 3) @(negedge clk);
    chk(rd == wr, "R3", rd, wr);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", rd, wr);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule